// File: doc/BRIEF.md
# TDM Channel Sequencer

This block produces the digital control for an N-channel sample-and-hold analog multiplexer that time-shares one cable. Each channel owns one slot of `SLOT` fast clock cycles. While a channel's slot is not active, its sample capacitor follows its input. When the slot begins, that capacitor is isolated from its input. The multiplexer switch that puts it on the output closes only after `DEAD` cycles of dead time. Because every select stays low for the first part of each slot, two selects are never high at the same moment.

Slots are served in Gray-code order, so that only one bit of the slot index changes from one slot to the next. After reset, the block leaves every switch in the tracking position for one full frame, which lets the capacitors settle before the first hold. A training request drives a registered enable for the bias resistors of the link-training pattern. Training does not disturb the slot sequence, so the receiver sees the pattern with normal timing.

Top module: `tdm_seq`

## Requirements
- R1: While `rst_n` is low, `sel`, `hold` and `train_en` are all 0.
- R2: For the first NCH*SLOT clock edges after reset is released, `sel` and `hold` stay all zero, so every channel tracks its input.
- R3: After that idle frame, running slot s (counted from 0, modulo NCH) serves channel s ^ (s >> 1), the Gray code of s. For NCH=8 the order is 0,1,3,2,6,7,5,4.
- R4: Throughout a running slot, `hold` is one-hot on the served channel (bit i = 1 means channel i is isolated from its input), and every other channel tracks.
- R5: Within a slot, the served channel's `sel` bit is low for the first DEAD cycles and high for the remaining SLOT-DEAD cycles.
- R6: At most one `sel` bit is high at any time, and a `sel` bit is high only while its `hold` bit is high.
- R7: After any `sel` bit falls, all `sel` bits stay low for at least DEAD cycles before another one rises.
- R8: `train_en` equals `train_req` delayed by one clock, and the slot sequence is the same whether training is on or off.
- R9: The frame repeats without gaps. Slot s+NCH serves the same channel, with the same timing, as slot s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast TDM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_req | input | 1 | Request for the link-training bias pattern |
| hold | output | NCH | Per-channel input isolate (1 = holding, 0 = tracking) |
| sel | output | NCH | Per-channel multiplexer select to the output driver |
| train_en | output | 1 | Enable for the training pull resistors |

## Verification
The assertions assume the parameters satisfy NCH a power of two, SLOT at least 2 and 1 <= DEAD < SLOT. They also assume that reset is held from time zero for at least one clock edge. The bench uses NCH=8, SLOT=5 and DEAD=2, which keeps within these limits and leaves a dead gap longer than one cycle. It toggles `train_req` and `rst_n` only at falling clock edges, and it applies a second reset in the middle of a running frame.

// File: rtl/tdm_seq.sv
module tdm_seq #(
  parameter int NCH  = 8,
  parameter int SLOT = 4,
  parameter int DEAD = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           train_req,
  output logic [NCH-1:0] hold,
  output logic [NCH-1:0] sel,
  output logic           train_en
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW = $clog2(SLOT);

  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;
  logic          run;

  wire           slot_end  = (ph == PW'(SLOT - 1));
  wire           frame_end = slot_end && (cnt == CW'(NCH - 1));
  wire [CW-1:0]  gry       = cnt ^ (cnt >> 1);
  wire           conn      = (ph >= PW'(DEAD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= '0;
      cnt      <= '0;
      run      <= 1'b0;
      train_en <= 1'b0;
    end else begin
      ph       <= slot_end ? '0 : ph + 1'b1;
      train_en <= train_req;
      if (slot_end) cnt <= frame_end ? '0 : cnt + 1'b1;
      if (frame_end) run <= 1'b1;
    end
  end

  always_comb begin
    hold = '0;
    sel  = '0;
    if (run) begin
      hold[gry] = 1'b1;
      sel[gry]  = conn;
    end
  end
endmodule

// File: rtl/tdm_seq_chk.sv
module tdm_seq_chk #(
  parameter int NCH  = 8,
  parameter int SLOT = 4,
  parameter int DEAD = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           train_req,
  input logic [NCH-1:0] hold,
  input logic [NCH-1:0] sel,
  input logic           train_en,
  input logic           run
);
  int   gap;
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (|sel) begin
      gap  <= 0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (sel == '0 && hold == '0));

  p_track_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sel & ~$past(sel))) |-> (|(sel & $past(hold))));

  p_one_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel) && $onehot0(hold));

  p_sel_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel & ~hold) == '0);

  p_no_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel) != '0 && sel != $past(sel)) |-> sel == '0);

  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && (|sel) && !(|$past(sel))) |-> gap >= DEAD);

  p_train_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    train_req |=> train_en);

  p_train_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !train_req |=> !train_en);
endmodule

bind tdm_seq tdm_seq_chk #(.NCH(NCH), .SLOT(SLOT), .DEAD(DEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .train_req(train_req), .hold(hold),
  .sel(sel), .train_en(train_en), .run(run)
);

// File: tb/tdm_seq_test.sv
`timescale 1ns/1ps
module tdm_seq_test;
  localparam int NCH  = 8;
  localparam int SLOT = 5;
  localparam int DEAD = 2;
  localparam int F    = NCH * SLOT;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           train_req = 1'b0;
  logic [NCH-1:0] hold, sel;
  logic           train_en;

  int errors = 0;
  int checks = 0;
  int k = 0;
  int gap = 0;
  bit seen = 1'b0;

  always #2 clk = ~clk;

  tdm_seq #(.NCH(NCH), .SLOT(SLOT), .DEAD(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .train_req(train_req),
    .hold(hold), .sel(sel), .train_en(train_en)
  );

  task automatic chk(input bit ok, input string req, input logic [NCH-1:0] act,
                     input logic [NCH-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at state %0d: actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic check_state();
    logic [NCH-1:0] eh, es;
    int j, s, ph, ch;
    if (k < F) begin
      chk(hold == '0, "R2 hold", hold, '0);
      chk(sel == '0, "R2 sel", sel, '0);
    end else begin
      j  = k - F;
      s  = (j / SLOT) % NCH;
      ph = j % SLOT;
      ch = s ^ (s >> 1);
      eh = '0; eh[ch] = 1'b1;
      es = (ph >= DEAD) ? eh : '0;
      chk(hold == eh, (j >= F) ? "R9 hold" : "R4 hold", hold, eh);
      chk(sel == es, (ph < DEAD) ? "R5 sel" : "R3 sel", sel, es);
    end
    chk($countones(sel) <= 1, "R6 onehot", sel, '0);
    if (|sel) begin
      if (seen && gap > 0) chk(gap >= DEAD, "R7 gap", NCH'(gap), NCH'(DEAD));
      gap = 0;
      seen = 1'b1;
    end else begin
      gap++;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    k++;
    check_state();
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sel == '0, "R1 sel", sel, '0);
    chk(hold == '0, "R1 hold", hold, '0);
    chk(train_en == 1'b0, "R1 train_en", NCH'(train_en), '0);
    rst_n = 1'b1;
    k = 0;
    gap = 0;
    seen = 1'b0;
    check_state();
  endtask

  task automatic t_idle();
    while (k < F - 1) step();
  endtask

  task automatic t_run(input int frames);
    repeat (frames * F) step();
  endtask

  task automatic t_training();
    train_req = 1'b1;
    step();
    chk(train_en == 1'b1, "R8 train on", NCH'(train_en), NCH'(1));
    repeat (F) begin
      step();
      chk(train_en == 1'b1, "R8 train held", NCH'(train_en), NCH'(1));
    end
    train_req = 1'b0;
    step();
    chk(train_en == 1'b0, "R8 train off", NCH'(train_en), '0);
  endtask

  task automatic t_mid_reset();
    repeat (13) step();
    t_reset();
    t_idle();
    t_run(1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_run(3);
    t_training();
    t_run(1);
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule